// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a stream of 18-bit parallel words into a single-wire serial stream. Each word is sent as a 20-bit frame. The frame opens with a fixed high start bit and closes with a fixed low stop bit. The low-to-high step from one frame's stop bit into the next frame's start bit gives a receiver a rising edge that recurs at every frame, and the receiver uses it as an embedded clock. The bit clock is a direct input, and the frame rate is exactly one twentieth of it. The block counts bit periods and raises a word strobe once per frame. The parallel word is sampled on the rising edge that ends a strobe cycle. That edge stands for the word-clock rising edge, so the word source runs on the same clock and uses the strobe as its enable.

While a sync request is high at a frame boundary, the payload is replaced by a lock pattern: nine ones, then nine zeros. With this pattern the only rising edge in the stream is the one at each start bit, so a receiver can find the frame boundary quickly. A captured word goes out one frame after it is sampled. Capture of parallel data continues through the first five consecutive sync frames and stops from the sixth onward, so the word held at that point is the first one sent once sync is released.

The serial output is qualified by an output-valid signal rather than a tri-state driver. The output stays idle and invalid until a clock-ready input shows that the bit clock is stable. A transmit power-down input also forces it idle. Dropping either condition clears the held word and the sync run count, so the next enable starts a fresh frame.

Top module: `emb_clk_serializer`

## Requirements
- R1: While `clk_rdy` is 0 or `tx_pwdn` is 1, `word_stb` is 0. From the next bit-clock edge, `ser_oe` and `ser_out` are both 0.
- R2: `word_stb` is 1 in the first bit-clock cycle in which the block is enabled. It is then 1 in every 20th cycle and 0 in all others. `din` and `sync_req` are sampled on the rising edge that ends a `word_stb` cycle (a boundary edge).
- R3: After each boundary edge, `ser_out` carries 20 consecutive frame bits, positions 0 to 19, with `ser_oe` at 1 for all of them. Position 0 (the start bit) is 1 and position 19 (the stop bit) is 0. Frames follow each other with no gap.
- R4: When `sync_req` is 0 at a boundary edge, frame position k+1 (k = 0..17) carries bit k of the word held from the previous capture. This gives a latency of one frame. The first frame after an enable carries an all-zero payload.
- R5: When `sync_req` is 1 at a boundary edge, positions 1 to 9 are 1 and positions 10 to 18 are 0. The frame then holds exactly one 0-to-1 transition, at its start bit.
- R6: Boundary edges with `sync_req` at 1 are counted while they are consecutive. On the 1st to 5th such edge `din` is still captured. From the 6th onward the held word is kept unchanged. A boundary edge with `sync_req` at 0 captures `din` and clears the count.
- R7: Losing the enable in the middle of a frame stops the frame at the next edge. It also clears the held word and the sync count. On re-enable, `word_stb` is 1 at once and a complete fresh frame follows.
- R8: While `rst_n` is 0, `ser_oe`, `ser_out` and `word_stb` are 0 without waiting for a clock edge. Internal reset ends on the second bit-clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, 20 times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_rdy | input | 1 | High once the bit clock is stable |
| tx_pwdn | input | 1 | Transmit power-down, active high |
| sync_req | input | 1 | Send lock pattern instead of data |
| din | input | 18 | Parallel payload word |
| word_stb | output | 1 | Frame boundary: `din` sampled at the end of this cycle |
| ser_out | output | 1 | Serial frame bit |
| ser_oe | output | 1 | Serial output valid |

## Verification
One boundary edge can do two jobs at once: it chooses the payload of the frame being launched, and it decides whether the incoming word is captured for the next frame. This matters most when `sync_req` falls. On that edge the lock pattern ends, the held word is launched, and a fresh word is captured, all together. The bench runs sync bursts of 1 to 8 frames, each framed by data frames. It judges the result from the payloads of the two frames after the release, compared against a simple hold-and-count model that tells whether the burst was long enough to freeze capture.

// File: rtl/emb_ser_pkg.sv
`timescale 1ns/1ps
package emb_ser_pkg;
  // payload source chosen at a frame boundary
  typedef enum logic {
    SRC_WORD = 1'b0,
    SRC_LOCK = 1'b1
  } frame_src_e;

  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;
endpackage

// File: rtl/emb_ser_rst_sync.sv
`timescale 1ns/1ps
module emb_ser_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/emb_ser_bit_timer.sv
`timescale 1ns/1ps
module emb_ser_bit_timer #(
  parameter int FRAME_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  output logic [$clog2(FRAME_W)-1:0] bit_idx,
  output logic                       load
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] idx_d, idx_q;

  always_comb begin
    load = run && (idx_q == LAST);
    if (!run)               idx_d = LAST;
    else if (idx_q == LAST) idx_d = '0;
    else                    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= LAST;
    else        idx_q <= idx_d;
  end

  assign bit_idx = idx_q;

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);

  assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
endmodule

// File: rtl/emb_ser_sync_gate.sv
`timescale 1ns/1ps
module emb_ser_sync_gate
  import emb_ser_pkg::*;
#(
  parameter int SYNC_HOLD = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic       sync_req,
  output frame_src_e src_sel,
  output logic       capture_en
);
  localparam int SC_W = $clog2(SYNC_HOLD + 1);
  localparam logic [SC_W-1:0] SAT   = SC_W'(SYNC_HOLD);
  localparam logic [SC_W-1:0] LIMIT = SC_W'(SYNC_HOLD - 1);

  logic [SC_W-1:0] streak_d, streak_q;
  logic            at_limit;

  always_comb begin
    at_limit   = (streak_q >= LIMIT);
    src_sel    = sync_req ? SRC_LOCK : SRC_WORD;
    capture_en = load && !(sync_req && at_limit);
    streak_d   = streak_q;
    if (!run) begin
      streak_d = '0;
    end else if (load) begin
      if (!sync_req)             streak_d = '0;
      else if (streak_q != SAT)  streak_d = streak_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak_q <= '0;
    else        streak_q <= streak_d;
  end

  assert_streak_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q <= SAT);

  assert_streak_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (streak_q == '0));
endmodule

// File: rtl/emb_ser_frame_shifter.sv
`timescale 1ns/1ps
module emb_ser_frame_shifter
  import emb_ser_pkg::*;
#(
  parameter int PAY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  frame_src_e       src_sel,
  input  logic             capture_en,
  input  logic [PAY_W-1:0] din,
  output logic             ser_out,
  output logic             ser_oe
);
  localparam int FRAME_W = PAY_W + 2;

  logic [PAY_W-1:0]   lock_pat;
  logic [PAY_W-1:0]   payload;
  logic [PAY_W-1:0]   hold_d, hold_q;
  logic [FRAME_W-1:0] shf_d, shf_q;
  logic               oe_d, oe_q;

  // lock pattern: first half of the payload ones, rest zeros, in send order
  for (genvar g = 0; g < PAY_W; g++) begin : g_lock
    assign lock_pat[g] = (g < PAY_W / 2);
  end

  always_comb begin
    payload = (src_sel == SRC_LOCK) ? lock_pat : hold_q;
    if (!run) begin
      hold_d = '0;
      shf_d  = '0;
      oe_d   = 1'b0;
    end else begin
      hold_d = capture_en ? din : hold_q;
      if (load) begin
        shf_d = {STOP_LVL, payload, START_LVL};
        oe_d  = 1'b1;
      end else begin
        shf_d = {1'b0, shf_q[FRAME_W-1:1]};
        oe_d  = oe_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      shf_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      shf_q  <= shf_d;
      oe_q   <= oe_d;
    end
  end

  assign ser_out = shf_q[0];
  assign ser_oe  = oe_q;

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_oe && ser_out));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ser_oe && !ser_out));

  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !capture_en) |=> $stable(hold_q));
endmodule

// File: rtl/emb_clk_serializer.sv
`timescale 1ns/1ps
module emb_clk_serializer
  import emb_ser_pkg::*;
#(
  parameter int PAY_W     = 18,
  parameter int SYNC_HOLD = 6
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             clk_rdy,
  input  logic             tx_pwdn,
  input  logic             sync_req,
  input  logic [PAY_W-1:0] din,
  output logic             word_stb,
  output logic             ser_out,
  output logic             ser_oe
);
  localparam int FRAME_W = PAY_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             srst_n;
  logic             run;
  logic             load;
  logic [CNT_W-1:0] bit_idx;
  frame_src_e       src_sel;
  logic             capture_en;

  emb_ser_rst_sync u_rst (
    .clk    (clk_bit),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign run = srst_n && clk_rdy && !tx_pwdn;

  emb_ser_bit_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk     (clk_bit),
    .rst_n   (srst_n),
    .run     (run),
    .bit_idx (bit_idx),
    .load    (load)
  );

  emb_ser_sync_gate #(.SYNC_HOLD(SYNC_HOLD)) u_gate (
    .clk        (clk_bit),
    .rst_n      (srst_n),
    .run        (run),
    .load       (load),
    .sync_req   (sync_req),
    .src_sel    (src_sel),
    .capture_en (capture_en)
  );

  emb_ser_frame_shifter #(.PAY_W(PAY_W)) u_shift (
    .clk        (clk_bit),
    .rst_n      (srst_n),
    .run        (run),
    .load       (load),
    .src_sel    (src_sel),
    .capture_en (capture_en),
    .din        (din),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe)
  );

  assign word_stb = load;

  assert_stop_bit_R3: assert property (@(posedge clk_bit) disable iff (!srst_n)
    (ser_oe && bit_idx == LAST) |-> !ser_out);

  assert_stb_gated_R1: assert property (@(posedge clk_bit) disable iff (!srst_n)
    (!clk_rdy || tx_pwdn) |-> !word_stb);
endmodule

// File: tb/emb_clk_serializer_tb.sv
`timescale 1ns/1ps
module emb_clk_serializer_tb;
  localparam int PW = 18;
  localparam int SH = 6;
  localparam logic [PW-1:0] LOCK = 18'h001FF; // positions 1..9 ones

  logic          clk = 1'b0;
  logic          rst_n, clk_rdy, tx_pwdn, sync_req;
  logic [PW-1:0] din;
  logic          word_stb, ser_out, ser_oe;

  int errs = 0, chks = 0;
  bit done = 0;
  logic [PW-1:0] hold_m;
  int streak_m;

  always #4 clk = ~clk;

  emb_clk_serializer #(.PAY_W(PW), .SYNC_HOLD(SH)) u_dut (
    .clk_bit(clk), .rst_n(rst_n), .clk_rdy(clk_rdy), .tx_pwdn(tx_pwdn),
    .sync_req(sync_req), .din(din), .word_stb(word_stb),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  // called at a negedge where a boundary is due; ends at the next one
  task automatic send(input logic s, input logic [PW-1:0] d, input string tag);
    logic [19:0] got, oes, exp;
    logic stb_seen, prev;
    int rises;
    sync_req = s;
    din      = d;
    check({tag, " R2 strobe at boundary"}, word_stb, 1);
    exp = {1'b0, (s ? LOCK : hold_m), 1'b1};
    if (s) begin
      if (streak_m < SH - 1) hold_m = d;
      if (streak_m < SH) streak_m++;
    end else begin
      hold_m   = d;
      streak_m = 0;
    end
    stb_seen = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      got[i] = ser_out;
      oes[i] = ser_oe;
      if (i < 19) stb_seen |= word_stb;
    end
    check({tag, s ? " R5 lock frame" : " R3/R4 data frame"}, got, exp);
    check({tag, " R3 valid through frame"}, oes, 20'hFFFFF);
    check({tag, " R2 no strobe inside frame"}, stb_seen, 0);
    if (s) begin
      rises = 0; prev = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (!prev && got[i]) rises++;
        prev = got[i];
      end
      check({tag, " R5 one rising edge"}, rises, 1);
    end
  endtask

  // begin a frame, then drop the enable a few bits in
  task automatic abort_frame(input bit by_pwdn, input string tag);
    sync_req = 1'b0;
    din      = 18'h2A5A5;
    @(posedge clk);
    repeat (5) @(negedge clk);
    if (by_pwdn) tx_pwdn = 1'b1; else clk_rdy = 1'b0;
    #1;
    check({tag, " R1 strobe off when disabled"}, word_stb, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check({tag, " R7 idle after disable"}, {ser_oe, ser_out, word_stb}, 0);
    end
    hold_m = '0;
    streak_m = 0;
    if (by_pwdn) tx_pwdn = 1'b0; else clk_rdy = 1'b1;
    #1;
    check({tag, " R7 strobe on re-enable"}, word_stb, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; clk_rdy = 1'b1; tx_pwdn = 1'b0; sync_req = 1'b0; din = '0;
    hold_m = '0; streak_m = 0;
    #3;
    check("R8 reset outputs before any edge", {ser_oe, ser_out, word_stb}, 0);
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {ser_oe, ser_out, word_stb}, 0);
    clk_rdy = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    clk_rdy = 1'b1; #1;
    check("R8 still in reset one edge after release", word_stb, 0);
    clk_rdy = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 idle while clock not ready", {ser_oe, ser_out, word_stb}, 0);
    end
    clk_rdy = 1'b1; #1;
    check("R2 strobe in first enabled cycle", word_stb, 1);

    // first frame after enable: zero payload, then walking ones
    send(1'b0, 18'h00001, "first");
    for (int b = 1; b < PW; b++) send(1'b0, 18'(1) << b, "walk");
    send(1'b0, 18'h3FFFF, "ones");
    send(1'b0, 18'h15555, "alt");
    send(1'b0, 18'h2AAAA, "alt2");

    // sync bursts of every length 1..8 (R6)
    for (int len = 1; len <= 8; len++) begin
      send(1'b0, 18'h10000 + 18'(len), "R6 pre");
      for (int k = 0; k < len; k++) send(1'b1, 18'h200 + 18'(len * 16 + k), "R6 burst");
      send(1'b0, 18'h30000 + 18'(len), "R6 release");
      send(1'b0, 18'h00F00 + 18'(len), "R6 after");
    end

    // power-down in mid-frame (R7)
    abort_frame(1'b1, "pwdn");
    send(1'b0, 18'h12345, "R7 after pwdn");
    send(1'b0, 18'h0ABCD, "R7 after pwdn 2");

    // clock-ready drop during a sync run clears the count (R7)
    for (int k = 0; k < 3; k++) send(1'b1, 18'h00100 + 18'(k), "R7 sync run");
    abort_frame(1'b0, "rdy");
    for (int k = 0; k < 5; k++) send(1'b1, 18'h00400 + 18'(k), "R7 sync restart");
    send(1'b0, 18'h3C3C3, "R7 release after restart");
    send(1'b0, 18'h0, "R7 tail");

    finish_run();
  end
endmodule